// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block owns the processor's 32-bit status word and decides, every clock cycle, whether an exception is taken. Seven event lines come in: reset request, undefined instruction, software interrupt, prefetch abort, data abort, interrupt and fast interrupt. The block masks the two interrupt lines with their disable bits in the status word and picks the single highest-ranked event that remains. On the next clock it presents a one-cycle `take` pulse. With that pulse it gives the vector address, the target mode code, the status word that was live before entry (for saving), and the return address for the link register.

When no exception is taken, software may overwrite the status word directly. Only the flag nibble and the low control byte store data; every other bit reads as zero. Fetching from the vector and flushing the pipeline belong to the surrounding core.

Top module: `exc_status_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `psr` equals 0x000000D3 (supervisor mode 10011, bits 7 and 6 set, flags clear) and `take` is 0.
- R2: With `sw_we` high and no exception taken, `psr` takes `sw_wdata` at the next clock edge. Bits 31..28 hold the N, Z, C, V flags, bit 7 disables interrupts, bit 6 disables fast interrupts, bit 5 is the compact-instruction state and bits 4..0 are the mode.
- R3: Bits 27..8 of `psr` always read as zero, and written values for those bits are discarded.
- R4: On entry `vec_addr` is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for interrupt and 0x1C for fast interrupt, zero-extended to ADDR_W.
- R5: On entry `new_mode` is 10011 for reset and software interrupt, 11011 for undefined, 10111 for either abort, 10010 for interrupt and 10001 for fast interrupt.
- R6: When several unmasked events are raised together, the one taken ranks highest in this order: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R7: An interrupt request is ignored while `psr` bit 7 is 1, and a fast-interrupt request is ignored while `psr` bit 6 is 1. Neither `take` nor `psr` changes.
- R8: On entry, `psr` bits 4..0 become the target mode, bit 7 becomes 1 and bit 5 becomes 0. Bit 6 becomes 1 for reset and fast interrupt and is otherwise kept. The flags are kept, except that a reset request clears them.
- R9: On entry, `saved_psr` equals `psr` as it was before the entry, and `link_addr` equals `cur_pc + RET_OFS` modulo 2^ADDR_W, where `cur_pc` is the value sampled with the events.
- R10: A taken exception overrides a software write in the same cycle; the write is discarded.
- R11: `take` is high for exactly the one cycle after the clock edge that sampled a taken event. It is 0 after a cycle with no unmasked event.
- R12: `vec_addr` is never 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| rst_req | input | 1 | Reset exception event |
| und_req | input | 1 | Undefined-instruction event |
| swi_req | input | 1 | Software-interrupt event |
| pabt_req | input | 1 | Prefetch-abort event |
| dabt_req | input | 1 | Data-abort event |
| irq_req | input | 1 | Interrupt request |
| fiq_req | input | 1 | Fast-interrupt request |
| cur_pc | input | ADDR_W | Address of the current instruction |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 32 | Status word value to write |
| psr | output | 32 | Current status word |
| take | output | 1 | One-cycle pulse: an exception was entered |
| vec_addr | output | ADDR_W | Vector address of the entered exception |
| new_mode | output | 5 | Mode code of the entered exception |
| saved_psr | output | 32 | Status word before entry, for saving |
| link_addr | output | ADDR_W | Return address for the link register |

## Verification
The bench builds the block with ADDR_W = 24 and RET_OFS = 8 rather than the defaults. The narrower address makes the return-address sum wrap within reach: an instruction address of 0xFFFFFC must yield a link address of 0x000004. The non-default offset shows that the increment comes from the parameter and not from a fixed constant. Status writes set up each mask and flag state before the events are raised, so masking, ranking and flag retention are each exercised from a known word.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int PSR_W     = 32;
   localparam int MODE_W    = 5;
   localparam int NUM_EXC   = 7;
   localparam int VEC_OFS_W = 5;

   localparam int POS_I = 7;
   localparam int POS_F = 6;
   localparam int POS_T = 5;

   // flag nibble and low control byte store data, the rest is hardwired zero
   localparam logic [PSR_W-1:0] PSR_LIVE = 32'hF000_00FF;

   localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

   localparam logic [PSR_W-1:0] PSR_RESET = {24'h0, 1'b1, 1'b1, 1'b0, MODE_SVC};

   // encoding equals rank: 0 wins over every other
   typedef enum logic [2:0] {
      EX_RST  = 3'd0,
      EX_DABT = 3'd1,
      EX_FIQ  = 3'd2,
      EX_IRQ  = 3'd3,
      EX_PABT = 3'd4,
      EX_UND  = 3'd5,
      EX_SWI  = 3'd6
   } exc_e;

   function automatic logic [MODE_W-1:0] exc_mode(input exc_e e);
      case (e)
         EX_RST, EX_SWI:   exc_mode = MODE_SVC;
         EX_UND:           exc_mode = MODE_UND;
         EX_PABT, EX_DABT: exc_mode = MODE_ABT;
         EX_IRQ:           exc_mode = MODE_IRQ;
         default:          exc_mode = MODE_FIQ;
      endcase
   endfunction

   function automatic logic [VEC_OFS_W-1:0] exc_vec_ofs(input exc_e e);
      case (e)
         EX_RST:  exc_vec_ofs = 5'h00;
         EX_UND:  exc_vec_ofs = 5'h04;
         EX_SWI:  exc_vec_ofs = 5'h08;
         EX_PABT: exc_vec_ofs = 5'h0C;
         EX_DABT: exc_vec_ofs = 5'h10;
         EX_IRQ:  exc_vec_ofs = 5'h18;
         default: exc_vec_ofs = 5'h1C;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
   import exc_pkg::*;
#(
   parameter int N = NUM_EXC
) (
   input  logic [N-1:0] req_i,
   input  logic         irq_off_i,
   input  logic         fiq_off_i,
   output logic         any_o,
   output exc_e         win_o
);

   if (N != NUM_EXC) begin : g_bad_n
      $error("exc_prio_sel: N must equal NUM_EXC");
   end

   logic [N-1:0] elig;
   logic [N-1:0] win;
   logic [N:0]   above;

   assign above[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      if (i == int'(EX_IRQ)) begin : g_irq
         assign elig[i] = req_i[i] & ~irq_off_i;
      end else if (i == int'(EX_FIQ)) begin : g_fiq
         assign elig[i] = req_i[i] & ~fiq_off_i;
      end else begin : g_plain
         assign elig[i] = req_i[i];
      end
      assign win[i]     = elig[i] & ~above[i];
      assign above[i+1] = above[i] | elig[i];
   end

   assign any_o = above[N];

   always_comb begin
      win_o = EX_RST;
      for (int k = 0; k < N; k++) begin
         if (win[k]) win_o = exc_e'(k[2:0]);
      end
   end

endmodule

// File: rtl/exc_psr_next.sv
module exc_psr_next
   import exc_pkg::*;
(
   input  logic [PSR_W-1:0] psr_i,
   input  logic             take_i,
   input  exc_e             sel_i,
   input  logic             sw_we_i,
   input  logic [PSR_W-1:0] sw_data_i,
   output logic [PSR_W-1:0] nxt_o
);

   logic [PSR_W-1:0] entry_w;

   always_comb begin
      entry_w               = psr_i & PSR_LIVE;
      entry_w[MODE_W-1:0]   = exc_mode(sel_i);
      entry_w[POS_I]        = 1'b1;
      entry_w[POS_T]        = 1'b0;
      if (sel_i == EX_RST || sel_i == EX_FIQ) entry_w[POS_F] = 1'b1;
      if (sel_i == EX_RST) entry_w[PSR_W-1 -: 4] = 4'h0;
   end

   always_comb begin
      if (take_i)       nxt_o = entry_w;
      else if (sw_we_i) nxt_o = sw_data_i & PSR_LIVE;
      else              nxt_o = psr_i & PSR_LIVE;
   end

endmodule

// File: rtl/exc_entry_out.sv
module exc_entry_out
   import exc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int RET_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  exc_e              sel_i,
   input  logic [PSR_W-1:0]  psr_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic              take_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic [MODE_W-1:0] mode_o,
   output logic [PSR_W-1:0]  saved_o,
   output logic [ADDR_W-1:0] link_o
);

   localparam logic [ADDR_W-1:0] RET_INC = ADDR_W'(RET_OFS);

   if (ADDR_W < VEC_OFS_W) begin : g_bad_w
      $error("exc_entry_out: ADDR_W too narrow for the vector table");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o  <= 1'b0;
         vec_o   <= '0;
         mode_o  <= '0;
         saved_o <= '0;
         link_o  <= '0;
      end else begin
         take_o <= take_i;
         if (take_i) begin
            vec_o   <= ADDR_W'(exc_vec_ofs(sel_i));
            mode_o  <= exc_mode(sel_i);
            saved_o <= psr_i;
            link_o  <= pc_i + RET_INC;
         end
      end
   end

endmodule

// File: rtl/exc_status_ctrl.sv
module exc_status_ctrl
   import exc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int RET_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic              und_req,
   input  logic              swi_req,
   input  logic              pabt_req,
   input  logic              dabt_req,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic              sw_we,
   input  logic [31:0]       sw_wdata,
   output logic [31:0]       psr,
   output logic              take,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [4:0]        new_mode,
   output logic [31:0]       saved_psr,
   output logic [ADDR_W-1:0] link_addr
);

   if (ADDR_W < VEC_OFS_W || ADDR_W > 64) begin : g_bad_addr
      $error("exc_status_ctrl: ADDR_W out of range");
   end
   if (RET_OFS < 0) begin : g_bad_ofs
      $error("exc_status_ctrl: RET_OFS must not be negative");
   end

   logic [NUM_EXC-1:0] req_rank;
   logic               take_now;
   exc_e               sel_now;
   logic [PSR_W-1:0]   psr_q;
   logic [PSR_W-1:0]   psr_d;

   assign req_rank[EX_RST]  = rst_req;
   assign req_rank[EX_DABT] = dabt_req;
   assign req_rank[EX_FIQ]  = fiq_req;
   assign req_rank[EX_IRQ]  = irq_req;
   assign req_rank[EX_PABT] = pabt_req;
   assign req_rank[EX_UND]  = und_req;
   assign req_rank[EX_SWI]  = swi_req;

   exc_prio_sel #(.N(NUM_EXC)) u_sel (
      .req_i     (req_rank),
      .irq_off_i (psr_q[POS_I]),
      .fiq_off_i (psr_q[POS_F]),
      .any_o     (take_now),
      .win_o     (sel_now)
   );

   exc_psr_next u_nxt (
      .psr_i     (psr_q),
      .take_i    (take_now),
      .sel_i     (sel_now),
      .sw_we_i   (sw_we),
      .sw_data_i (sw_wdata),
      .nxt_o     (psr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psr_q <= PSR_RESET;
      else        psr_q <= psr_d;
   end

   exc_entry_out #(.ADDR_W(ADDR_W), .RET_OFS(RET_OFS)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take_now),
      .sel_i   (sel_now),
      .psr_i   (psr_q),
      .pc_i    (cur_pc),
      .take_o  (take),
      .vec_o   (vec_addr),
      .mode_o  (new_mode),
      .saved_o (saved_psr),
      .link_o  (link_addr)
   );

   assign psr = psr_q;

endmodule

// File: rtl/exc_status_chk.sv
module exc_status_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_req,
   input logic              und_req,
   input logic              swi_req,
   input logic              pabt_req,
   input logic              dabt_req,
   input logic              irq_req,
   input logic              fiq_req,
   input logic [31:0]       psr,
   input logic              take,
   input logic [ADDR_W-1:0] vec_addr,
   input logic [4:0]        new_mode,
   input logic [31:0]       saved_psr
);

   logic others_idle;
   assign others_idle = !(rst_req | dabt_req | pabt_req | und_req | swi_req);

   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psr[27:8] == 20'h0);

   // R12
   no_vec14_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> vec_addr != ADDR_W'(5'h14));

   // R9
   saved_psr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> saved_psr == $past(psr));

   // R8
   entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (psr[7] && !psr[5] && psr[4:0] == new_mode));

   // R7
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && psr[7] && !fiq_req && others_idle) |=> !take);

   // R7
   fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req && psr[6] && !irq_req && others_idle) |=> !take);

   // R10
   rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (take && vec_addr == '0 && psr == 32'h0000_00D3));

   // R11
   idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (others_idle && !irq_req && !fiq_req) |=> !take);

endmodule

bind exc_status_ctrl exc_status_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_req   (rst_req),
   .und_req   (und_req),
   .swi_req   (swi_req),
   .pabt_req  (pabt_req),
   .dabt_req  (dabt_req),
   .irq_req   (irq_req),
   .fiq_req   (fiq_req),
   .psr       (psr),
   .take      (take),
   .vec_addr  (vec_addr),
   .new_mode  (new_mode),
   .saved_psr (saved_psr)
);

// File: tb/tb_exc_status_ctrl.sv
`timescale 1ns/1ps
module tb_exc_status_ctrl;

   localparam int AW  = 24;
   localparam int OFS = 8;

   // bench-side event bit positions
   localparam int Q_RST = 0, Q_UND = 1, Q_SWI = 2, Q_PABT = 3,
                  Q_DABT = 4, Q_IRQ = 5, Q_FIQ = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [6:0]    rq = '0;
   logic [AW-1:0] cur_pc = '0;
   logic          sw_we = 1'b0;
   logic [31:0]   sw_wdata = '0;
   logic [31:0]   psr;
   logic          take;
   logic [AW-1:0] vec_addr;
   logic [4:0]    new_mode;
   logic [31:0]   saved_psr;
   logic [AW-1:0] link_addr;

   always #2.5 clk = ~clk;

   exc_status_ctrl #(.ADDR_W(AW), .RET_OFS(OFS)) dut (
      .clk(clk), .rst_n(rst_n),
      .rst_req(rq[Q_RST]), .und_req(rq[Q_UND]), .swi_req(rq[Q_SWI]),
      .pabt_req(rq[Q_PABT]), .dabt_req(rq[Q_DABT]),
      .irq_req(rq[Q_IRQ]), .fiq_req(rq[Q_FIQ]),
      .cur_pc(cur_pc), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .psr(psr), .take(take), .vec_addr(vec_addr), .new_mode(new_mode),
      .saved_psr(saved_psr), .link_addr(link_addr)
   );

   typedef struct {
      logic          tk;
      logic [AW-1:0] vec;
      logic [AW-1:0] lnk;
      logic [4:0]    mode;
      logic [31:0]   saved;
      logic [31:0]   nps;
      string         tag;
   } exp_t;

   exp_t        expq[$];
   int          checks = 0;
   int          errors = 0;
   logic [31:0] m_psr = 32'h0000_00D3;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // driver: drive one cycle of stimulus and queue what must follow
   task automatic step(input logic [6:0] r, input logic [AW-1:0] pc,
                       input logic we, input logic [31:0] wd, input string tag);
      exp_t e;
      logic [31:0] np;
      @(negedge clk);
      rq = r; cur_pc = pc; sw_we = we; sw_wdata = wd;
      e.tk = 1'b1; e.vec = '0; e.mode = '0; e.tag = tag;
      if (r[Q_RST])                    begin e.vec = 'h00; e.mode = 5'b10011; end
      else if (r[Q_DABT])              begin e.vec = 'h10; e.mode = 5'b10111; end
      else if (r[Q_FIQ] && !m_psr[6])  begin e.vec = 'h1C; e.mode = 5'b10001; end
      else if (r[Q_IRQ] && !m_psr[7])  begin e.vec = 'h18; e.mode = 5'b10010; end
      else if (r[Q_PABT])              begin e.vec = 'h0C; e.mode = 5'b10111; end
      else if (r[Q_UND])               begin e.vec = 'h04; e.mode = 5'b11011; end
      else if (r[Q_SWI])               begin e.vec = 'h08; e.mode = 5'b10011; end
      else e.tk = 1'b0;
      e.saved = m_psr;
      e.lnk   = pc + AW'(OFS);
      if (e.tk) begin
         np = {m_psr[31:28], 20'h0, 1'b1, m_psr[6], 1'b0, e.mode};
         if (r[Q_RST] || e.mode == 5'b10001) np[6] = 1'b1;
         if (r[Q_RST]) np[31:28] = 4'h0;
      end else if (we) begin
         np = {wd[31:28], 20'h0, wd[7:0]};
      end else begin
         np = m_psr;
      end
      e.nps = np;
      m_psr = np;
      expq.push_back(e);
   endtask

   // monitor: one expectation per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk({e.tag, " take"}, 64'(take), 64'(e.tk));
            chk({e.tag, " psr"},  64'(psr),  64'(e.nps));
            if (e.tk) begin
               chk("R4 vec_addr",   64'(vec_addr),  64'(e.vec));
               chk("R5 new_mode",   64'(new_mode),  64'(e.mode));
               chk("R9 saved_psr",  64'(saved_psr), 64'(e.saved));
               chk("R9 link_addr",  64'(link_addr), 64'(e.lnk));
               chk("R12 vec not 14", 64'(vec_addr == AW'(5'h14)), 64'(0));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam logic [6:0] NONE = 7'b0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 psr in reset", 64'(psr), 64'h0000_00D3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 psr after reset", 64'(psr), 64'h0000_00D3);
      chk("R1 take after reset", 64'(take), 64'(0));

      step(NONE, 'h000100, 1'b0, 32'h0, "R11");
      step(NONE, 'h000104, 1'b1, 32'hA5A5_A510, "R2");
      step(NONE, 'h000108, 1'b1, 32'hFFFF_FFFF, "R3");
      step(NONE, 'h00010C, 1'b1, 32'hA000_0010, "R2");
      step(7'(1 << Q_IRQ), 'h001000, 1'b0, 32'h0, "R8");
      step(7'(1 << Q_IRQ), 'h001004, 1'b0, 32'h0, "R7");
      step(NONE, 'h001008, 1'b1, 32'h5000_0010, "R2");
      step(7'((1 << Q_FIQ) | (1 << Q_IRQ) | (1 << Q_PABT)), 'h002000, 1'b0, 32'h0, "R6");
      step(NONE, 'h002004, 1'b1, 32'h0000_0050, "R2");
      step(7'(1 << Q_FIQ), 'h002008, 1'b0, 32'h0, "R7");
      step(7'((1 << Q_FIQ) | (1 << Q_IRQ)), 'h00200C, 1'b0, 32'h0, "R7");
      step(NONE, 'h002010, 1'b1, 32'h0000_0010, "R2");
      step(7'b1111110, 'h003000, 1'b0, 32'h0, "R6");
      step(NONE, 'h003004, 1'b1, 32'h0000_0010, "R2");
      step(7'((1 << Q_PABT) | (1 << Q_UND) | (1 << Q_SWI)), 'h003008, 1'b0, 32'h0, "R6");
      step(NONE, 'h00300C, 1'b1, 32'h0000_0010, "R2");
      step(7'((1 << Q_UND) | (1 << Q_SWI)), 'h003010, 1'b0, 32'h0, "R6");
      step(NONE, 'h003014, 1'b1, 32'h0000_0010, "R2");
      step(7'(1 << Q_SWI), 'h003018, 1'b0, 32'h0, "R5");
      step(NONE, 'h00301C, 1'b1, 32'hF000_0010, "R2");
      step(7'b1111111, 'h004000, 1'b1, 32'h0000_0000, "R10");
      step(NONE, 'h004004, 1'b1, 32'hF000_0010, "R2");
      step(7'(1 << Q_DABT), 'h004008, 1'b1, 32'hF000_00FF, "R10");
      step(7'(1 << Q_SWI), 'hFFFFFC, 1'b0, 32'h0, "R9");
      step(NONE, 'h005000, 1'b0, 32'h0, "R11");
      @(negedge clk);
      rq = '0; sw_we = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule